// File: doc/BRIEF.md
# Receive Sampling-Delay Tuning Search

This controller picks the receive sampling delay for a high-speed eMMC link. After a start request, it sweeps a 6-bit tune value upward from 0. For each value it first programs the setting through an apply handshake, then asks an external tester to run a tuning transfer, and it records whether that value passed. While it sweeps, it keeps the length and end position of the longest run of consecutive passing values. When the sweep ends, it programs the middle of that run and reports done. If no value passed, it reports an error instead.

The physical delay line has a timing weakness, so every programming step is made of two full request/acknowledge handshakes with a gap between them. A handshake that is never acknowledged counts as a failing value and does not stop the sweep. The block only accepts the HS200 tuning command, which is opcode 21. Any other opcode ends the run at once with an error.

Top module: `tune_search`

## Requirements
- R1: After reset, done, error, apply_req and test_req are low and tune_val is 0.
- R2: A start pulse whose opcode is not 21 produces a done pulse with error high, and no apply_req or test_req is raised for that start.
- R3: With opcode 21, the block programs tune values 0, 1, ... up to SWEEP_LEN-1 (39 by default), in ascending order and never higher. Each programming step is two apply_req/apply_ack handshakes, and apply_req is low for at least one cycle after each accepted acknowledge.
- R4: After a programming step succeeds, test_req is held high until test_done. test_pass is sampled in that cycle, and test_req is never high together with apply_req.
- R5: If apply_ack does not arrive within ACK_TIMEOUT cycles of apply_req rising, that tune value counts as failing and no test_req is issued for it.
- R6: A passing value adds one to the current run and a failing value clears it. The best run is replaced only by a strictly longer run, so the earliest of equal-length runs wins. The run end is recorded as the last passing value plus one.
- R7: After the sweep, the chosen value is run_end - run_length/2 (integer division). It is programmed with the same double handshake, and then done pulses with error low.
- R8: If no value passed, done pulses with error high and no further apply_req is raised.
- R9: done is high for exactly one cycle. error and tune_val then stay unchanged until the next start.
- R10: If the final programming of the chosen value times out, done pulses with error high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to begin a search |
| opcode | input | OPC_W | Command opcode the search is run for |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | Search failed or opcode rejected; valid from done |
| tune_val | output | TUNE_W | Tune value being programmed, then the result |
| apply_req | output | 1 | Request to program tune_val into the delay line |
| apply_ack | input | 1 | Programming of tune_val has taken effect |
| test_req | output | 1 | Request for one tuning transfer at the current value |
| test_done | input | 1 | Tuning transfer finished |
| test_pass | input | 1 | Result of the transfer, valid with test_done |

## Verification
The bench uses the default width, sweep length of 40, repeat count of 2 and opcode 21, so the real 0..39 range and its end cases are covered: runs that touch value 39, a full-range run, and a single-value run whose formula result lies outside it. ACK_TIMEOUT is cut to 8 so that the timeout paths finish in a few cycles. With an acknowledge latency of 3, normal handshakes stay well inside that window, while blocked or rationed acknowledges drive both the mid-sweep timeout and the final-apply timeout.

// File: rtl/tune_search_pkg.sv
package tune_search_pkg;

    typedef enum logic [2:0] {
        TS_IDLE,
        TS_APPLY,
        TS_TEST,
        TS_NEXT,
        TS_DECIDE,
        TS_FINAL
    } ts_state_e;

    typedef enum logic [1:0] {
        AP_IDLE,
        AP_REQ,
        AP_GAP
    } ap_state_e;

    typedef struct packed {
        logic valid;
        logic ok;
    } ap_result_t;

    // middle of a passing run given its exclusive end and its length
    function automatic int unsigned window_centre(input int unsigned run_end,
                                                  input int unsigned run_len);
        return run_end - run_len / 2;
    endfunction

endpackage

// File: rtl/tune_apply_seq.sv
module tune_apply_seq
    import tune_search_pkg::*;
#(
    parameter int REPEAT  = 2,
    parameter int TIMEOUT = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       go,
    input  logic       apply_ack,
    output logic       apply_req,
    output ap_result_t res
);
    localparam int REP_W = $clog2(REPEAT + 1);
    localparam int TMO_W = $clog2(TIMEOUT + 1);

    ap_state_e      st;
    logic [REP_W-1:0] rep;
    logic [TMO_W-1:0] tmr;

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= AP_IDLE;
            rep <= '0;
            tmr <= '0;
            res <= '0;
        end else begin
            res.valid <= 1'b0;
            case (st)
                AP_IDLE: if (go) begin
                    st  <= AP_REQ;
                    rep <= '0;
                    tmr <= '0;
                end
                AP_REQ: begin
                    if (apply_ack) begin
                        tmr <= '0;
                        if (rep == REP_W'(REPEAT - 1)) begin
                            st  <= AP_IDLE;
                            res <= '{valid: 1'b1, ok: 1'b1};
                        end else begin
                            rep <= rep + 1'b1;
                            st  <= AP_GAP;
                        end
                    end else if (tmr == TMO_W'(TIMEOUT - 1)) begin
                        st  <= AP_IDLE;
                        res <= '{valid: 1'b1, ok: 1'b0};
                    end else begin
                        tmr <= tmr + 1'b1;
                    end
                end
                AP_GAP:  st <= AP_REQ;
                default: st <= AP_IDLE;
            endcase
        end
    end

    assign apply_req = (st == AP_REQ);

    AST_REQ_DROPS_AFTER_ACK: assert property (@(posedge clk) disable iff (rst)
        apply_req && apply_ack |=> !apply_req); // R3
    AST_RESULT_AFTER_REQ: assert property (@(posedge clk) disable iff (rst)
        res.valid |-> $past(apply_req)); // R5

endmodule

// File: rtl/tune_streak_trk.sv
module tune_streak_trk #(
    parameter int IDX_W = 6,
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             step_en,
    input  logic             step_pass,
    input  logic [IDX_W-1:0] step_idx,
    output logic [CNT_W-1:0] best_len,
    output logic [CNT_W-1:0] best_end
);
    logic [CNT_W-1:0] cur_len;
    logic [CNT_W-1:0] cur_next;

    assign cur_next = cur_len + CNT_W'(1);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cur_len  <= '0;
            best_len <= '0;
            best_end <= '0;
        end else if (step_en) begin
            if (step_pass) begin
                cur_len <= cur_next;
                if (cur_next > best_len) begin
                    best_len <= cur_next;
                    best_end <= CNT_W'(step_idx) + CNT_W'(1);
                end
            end else begin
                cur_len <= '0;
            end
        end
    end

    AST_BEST_COVERS_RUN: assert property (@(posedge clk) disable iff (rst)
        best_len >= cur_len); // R6
    AST_FAIL_CLEARS_RUN: assert property (@(posedge clk) disable iff (rst)
        step_en && !step_pass && !clr |=> cur_len == '0); // R6

endmodule

// File: rtl/tune_search.sv
module tune_search
    import tune_search_pkg::*;
#(
    parameter int TUNE_W       = 6,
    parameter int SWEEP_LEN    = 40,
    parameter int APPLY_REPEAT = 2,
    parameter int ACK_TIMEOUT  = 16,
    parameter int OPC_W        = 6,
    parameter int TUNE_OPCODE  = 21
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [OPC_W-1:0]  opcode,
    output logic              done,
    output logic              error,
    output logic [TUNE_W-1:0] tune_val,
    output logic              apply_req,
    input  logic              apply_ack,
    output logic              test_req,
    input  logic              test_done,
    input  logic              test_pass
);
    localparam int                CNT_W  = $clog2(SWEEP_LEN + 1);
    localparam logic [TUNE_W-1:0] LAST_V = TUNE_W'(SWEEP_LEN - 1);

    ts_state_e         st;
    logic [TUNE_W-1:0] idx;
    logic [TUNE_W-1:0] tune_q;
    logic              done_q, err_q, test_q;
    logic              ap_go, trk_clr, step_en, step_pass;
    ap_result_t        ap_res;
    logic [CNT_W-1:0]  best_len, best_end;

    tune_apply_seq #(.REPEAT(APPLY_REPEAT), .TIMEOUT(ACK_TIMEOUT)) u_apply (
        .clk(clk), .rst(rst), .go(ap_go), .apply_ack(apply_ack),
        .apply_req(apply_req), .res(ap_res)
    );

    tune_streak_trk #(.IDX_W(TUNE_W), .CNT_W(CNT_W)) u_trk (
        .clk(clk), .rst(rst), .clr(trk_clr), .step_en(step_en),
        .step_pass(step_pass), .step_idx(idx),
        .best_len(best_len), .best_end(best_end)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= TS_IDLE;
            idx       <= '0;
            tune_q    <= '0;
            done_q    <= 1'b0;
            err_q     <= 1'b0;
            test_q    <= 1'b0;
            ap_go     <= 1'b0;
            trk_clr   <= 1'b0;
            step_en   <= 1'b0;
            step_pass <= 1'b0;
        end else begin
            done_q  <= 1'b0;
            ap_go   <= 1'b0;
            trk_clr <= 1'b0;
            step_en <= 1'b0;
            case (st)
                TS_IDLE: if (start && !done_q) begin
                    if (opcode != OPC_W'(TUNE_OPCODE)) begin
                        err_q  <= 1'b1;
                        done_q <= 1'b1;
                    end else begin
                        err_q   <= 1'b0;
                        idx     <= '0;
                        tune_q  <= '0;
                        trk_clr <= 1'b1;
                        ap_go   <= 1'b1;
                        st      <= TS_APPLY;
                    end
                end
                TS_APPLY: if (ap_res.valid) begin
                    if (ap_res.ok) begin
                        test_q <= 1'b1;
                        st     <= TS_TEST;
                    end else begin
                        step_en   <= 1'b1;
                        step_pass <= 1'b0;
                        st        <= TS_NEXT;
                    end
                end
                TS_TEST: if (test_done) begin
                    test_q    <= 1'b0;
                    step_en   <= 1'b1;
                    step_pass <= test_pass;
                    st        <= TS_NEXT;
                end
                TS_NEXT: begin
                    if (idx == LAST_V) begin
                        st <= TS_DECIDE;
                    end else begin
                        idx    <= idx + 1'b1;
                        tune_q <= idx + 1'b1;
                        ap_go  <= 1'b1;
                        st     <= TS_APPLY;
                    end
                end
                TS_DECIDE: begin
                    if (best_len == '0) begin
                        err_q  <= 1'b1;
                        done_q <= 1'b1;
                        st     <= TS_IDLE;
                    end else begin
                        tune_q <= TUNE_W'(window_centre(int'(best_end), int'(best_len)));
                        ap_go  <= 1'b1;
                        st     <= TS_FINAL;
                    end
                end
                TS_FINAL: if (ap_res.valid) begin
                    err_q  <= !ap_res.ok;
                    done_q <= 1'b1;
                    st     <= TS_IDLE;
                end
                default: st <= TS_IDLE;
            endcase
        end
    end

    assign done     = done_q;
    assign error    = err_q;
    assign tune_val = tune_q;
    assign test_req = test_q;

    AST_TUNE_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        apply_req |-> tune_val <= LAST_V); // R3
    AST_REQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(apply_req && test_req)); // R4
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R9
    AST_ERROR_QUIET: assert property (@(posedge clk) disable iff (rst)
        done && error |-> !apply_req && !test_req); // R8
    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (rst)
        st == TS_IDLE && !start |=> $stable(tune_val) && $stable(error)); // R9

endmodule

// File: tb/tb_tune_search.sv
module tb_tune_search;
    localparam int SWEEP = 40;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic [5:0] opcode = 6'd0;
    logic       done, error, apply_req, test_req;
    logic [5:0] tune_val;
    logic       apply_ack = 1'b0;
    logic       test_done = 1'b0;
    logic       test_pass = 1'b0;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    bit finished = 1'b0;

    logic [63:0] pass_mask = '0;
    logic [63:0] block_mask = '0;
    int ack_delay = 3;
    int test_delay = 2;
    int ack_limit = 1000000;
    int acks[64];
    int tests[64];
    int ack_total = 0;
    int test_total = 0;
    int aw = 0;
    int tw = 0;

    always #10 clk = ~clk;

    tune_search #(.ACK_TIMEOUT(8)) dut (
        .clk(clk), .rst(rst), .start(start), .opcode(opcode),
        .done(done), .error(error), .tune_val(tune_val),
        .apply_req(apply_req), .apply_ack(apply_ack),
        .test_req(test_req), .test_done(test_done), .test_pass(test_pass)
    );

    // apply responder
    always @(negedge clk) begin
        if (apply_ack) begin
            apply_ack = 1'b0;
            aw = 0;
        end else if (apply_req && !block_mask[tune_val] && ack_total < ack_limit) begin
            aw++;
            if (aw >= ack_delay) begin
                apply_ack = 1'b1;
                acks[tune_val]++;
                ack_total++;
            end
        end else begin
            aw = 0;
        end
    end

    // tuning-transfer responder
    always @(negedge clk) begin
        if (test_done) begin
            test_done = 1'b0;
            tw = 0;
        end else if (test_req) begin
            tw++;
            if (tw >= test_delay) begin
                test_done = 1'b1;
                test_pass = pass_mask[tune_val];
                tests[tune_val]++;
                test_total++;
            end
        end else begin
            tw = 0;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000 && !finished) begin
            fails++;
            checks++;
            $display("FAIL R3 watchdog expired: actual cycles %0d expected fewer", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic void model(input logic [63:0] pm, output int centre, output bit found);
        int cur = 0;
        int best = 0;
        int endi = 0;
        for (int v = 0; v < SWEEP; v++) begin
            if (pm[v]) begin
                cur++;
                if (cur > best) begin
                    best = cur;
                    endi = v + 1;
                end
            end else begin
                cur = 0;
            end
        end
        found = (best > 0);
        centre = endi - best / 2;
    endfunction

    task automatic clear_counts();
        for (int v = 0; v < 64; v++) begin
            acks[v] = 0;
            tests[v] = 0;
        end
        ack_total = 0;
        test_total = 0;
    endtask

    // start a run and wait for done; checks the pulse width and holding
    task automatic run(input logic [5:0] opc, output int got_val, output bit got_err);
        int waited = 0;
        clear_counts();
        @(negedge clk);
        opcode = opc;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!done && waited < 20000) begin
            @(negedge clk);
            waited++;
        end
        check(done == 1'b1, "R9 done seen", int'(done), 1);
        got_val = int'(tune_val);
        got_err = error;
        @(negedge clk);
        check(done == 1'b0, "R9 done one cycle", int'(done), 0);
        repeat (4) @(negedge clk);
        check(int'(tune_val) == got_val, "R9 tune_val held", int'(tune_val), got_val);
        check(error == got_err, "R9 error held", int'(error), int'(got_err));
    endtask

    // full sweep scenario with expected values computed by the model
    task automatic sweep_case(input string name, input logic [63:0] pm, input logic [63:0] bm);
        int c, gv, bad_a, bad_t, ea, et;
        bit f, ge;
        pass_mask = pm;
        block_mask = bm;
        model(pm & ~bm, c, f);
        run(6'd21, gv, ge);
        check(ge == !f, {name, " R8 error flag"}, int'(ge), int'(!f));
        if (f) check(gv == c, {name, " R7 chosen value"}, gv, c);
        bad_a = 0;
        bad_t = 0;
        for (int v = 0; v < 64; v++) begin
            ea = (v < SWEEP && !bm[v]) ? 2 : 0;
            if (f && v == c) ea += 2;
            et = (v < SWEEP && !bm[v]) ? 1 : 0;
            if (acks[v] != ea) bad_a++;
            if (tests[v] != et) bad_t++;
        end
        check(bad_a == 0, {name, " R3 double handshake per value"}, bad_a, 0);
        check(bad_t == 0, {name, " R4 R5 one test per programmed value"}, bad_t, 0);
    endtask

    task automatic t_reset();
        check(done == 1'b0 && error == 1'b0, "R1 done/error after reset", int'({done, error}), 0);
        check(apply_req == 1'b0 && test_req == 1'b0, "R1 requests after reset",
              int'({apply_req, test_req}), 0);
        check(tune_val == 6'd0, "R1 tune_val after reset", int'(tune_val), 0);
    endtask

    task automatic t_single_window();
        sweep_case("R6 window 10..19", 64'h0000_0000_000F_FC00, '0);
        check(int'(tune_val) == 15, "R7 centre of 10..19", int'(tune_val), 15);
    endtask

    task automatic t_two_windows();
        logic [63:0] m = '0;
        for (int v = 3; v <= 5; v++) m[v] = 1'b1;
        for (int v = 20; v <= 26; v++) m[v] = 1'b1;
        sweep_case("R6 longer later window", m, '0);
        check(int'(tune_val) == 24, "R6 later longer run chosen", int'(tune_val), 24);
    endtask

    task automatic t_tie();
        logic [63:0] m = '0;
        for (int v = 0; v <= 3; v++) m[v] = 1'b1;
        for (int v = 10; v <= 13; v++) m[v] = 1'b1;
        sweep_case("R6 equal runs", m, '0);
        check(int'(tune_val) == 2, "R6 earliest equal run wins", int'(tune_val), 2);
    endtask

    task automatic t_top_edge();
        logic [63:0] m = '0;
        for (int v = 30; v <= 63; v++) m[v] = 1'b1;
        sweep_case("R3 run to 39", m, '0);
        check(int'(tune_val) == 35, "R3 R7 values above 39 not swept", int'(tune_val), 35);
    endtask

    task automatic t_all_pass();
        sweep_case("R7 all pass", '1, '0);
        check(int'(tune_val) == 20, "R7 full range centre", int'(tune_val), 20);
    endtask

    task automatic t_single_point();
        logic [63:0] m = '0;
        m[9] = 1'b1;
        sweep_case("R7 single pass", m, '0);
        check(int'(tune_val) == 10, "R7 single pass end-len/2", int'(tune_val), 10);
    endtask

    task automatic t_none();
        sweep_case("R8 none pass", '0, '0);
        check(error == 1'b1, "R8 error when nothing passes", int'(error), 1);
        check(ack_total == 2 * SWEEP, "R8 no final apply", ack_total, 2 * SWEEP);
    endtask

    task automatic t_timeout();
        logic [63:0] b = '0;
        b[20] = 1'b1;
        sweep_case("R5 blocked value", '1, b);
        check(tests[20] == 0, "R5 no test after timeout", tests[20], 0);
        check(int'(tune_val) == 10, "R5 timeout splits run", int'(tune_val), 10);
    endtask

    task automatic t_bad_opcode();
        int gv;
        bit ge;
        pass_mask = '1;
        block_mask = '0;
        run(6'd19, gv, ge);
        check(ge == 1'b1, "R2 other opcode rejected", int'(ge), 1);
        check(ack_total == 0 && test_total == 0, "R2 no requests on reject",
              ack_total + test_total, 0);
    endtask

    task automatic t_final_timeout();
        int gv;
        bit ge;
        pass_mask = '1;
        block_mask = '0;
        ack_limit = 2 * SWEEP;
        run(6'd21, gv, ge);
        ack_limit = 1000000;
        check(ge == 1'b1, "R10 final apply timeout flags error", int'(ge), 1);
        check(gv == 20, "R10 chosen value still shown", gv, 20);
        check(ack_total == 2 * SWEEP, "R10 final apply never acked", ack_total, 2 * SWEEP);
    endtask

    initial begin
        clear_counts();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_single_window();
        t_two_windows();
        t_tie();
        t_top_edge();
        t_all_pass();
        t_single_point();
        t_none();
        t_timeout();
        t_bad_opcode();
        ack_delay = 1;
        test_delay = 5;
        t_two_windows();
        ack_delay = 3;
        test_delay = 2;
        t_final_timeout();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule